// File: doc/BRIEF.md
# Warp Regrouping Unit

This unit rebuilds SIMD warps after a branch, so that threads heading for the same program counter share one issue slot even when they come from different static warps. Each branch outcome arrives as one transfer carrying the thread IDs of a four-lane warp, the taken target with its lane mask, and the fall-through target with its lane mask. The two groups are staged, then folded one per cycle into a small pool of warps under construction. A PC-keyed table records which lanes of the newest pool warp for each target are already filled.

A thread never leaves its home lane. A group whose lanes are all still free in the table entry for its PC is merged into that pool warp. If any lane is already taken, the group starts a fresh pool warp and the table entry is re-pointed to it. The issue side presents one pool warp at a time. It chooses the warp holding the most threads, and on a tie the lowest pool slot.

Both data edges use valid/ready. `in_ready` is high only when neither staged group is pending, so an outcome is taken whole or not at all. When the pool has no free slot, the pending group waits and `in_ready` stays low until an issued warp frees a slot. On the output side, a warp shown with `out_valid` high and `out_ready` low stays selected until accepted. Its PC stays fixed, and it can only gain lanes from further merges.

Top module: `warp_regroup`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: A thread ID that enters on lane i, where lane i is bits [i*TID_W +: TID_W] of `in_tid` and bit i of a mask, leaves on the same lane of `out_tid`. Lanes whose bit is clear in `out_mask` read as zero.
- R3: Groups for the same PC whose lanes do not collide with those already filled are combined into one issued warp whose mask is the union of theirs.
- R4: A group whose lanes collide with lanes already filled for its PC opens a separate pool warp. Both warps are issued, each with only its own threads.
- R5: The issued warp is the pool warp with the most active lanes.
- R6: Among pool warps of equal size, the lowest pool slot issues first. A new warp takes the lowest free slot.
- R7: Within one outcome, the taken group is placed before the fall-through group, so with equal sizes the taken warp issues first.
- R8: With every pool slot occupied, a group that needs a new warp waits and `in_ready` stays low. It is placed once an issue frees a slot.
- R9: Issuing a warp releases its pool slot and its table entry. A later group for the same PC forms a new warp that holds only the later threads.
- R10: While `out_valid` is high and `out_ready` low, the next cycle keeps `out_valid` high with the same `out_pc`, and no lane of `out_mask` is lost.
- R11: A group with an all-zero lane mask is discarded and produces no warp. An issued warp never has an empty mask.
- R12: Once an outcome with any nonzero mask is accepted, `in_ready` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Branch outcome offered |
| in_ready | output | 1 | Unit can take a branch outcome |
| in_tk_pc | input | PC_W | Target PC of the taken group |
| in_tk_mask | input | LANES | Lanes that took the branch |
| in_nt_pc | input | PC_W | Fall-through PC |
| in_nt_mask | input | LANES | Lanes that fell through |
| in_tid | input | LANES*TID_W | Thread ID of each lane of the static warp |
| out_valid | output | 1 | A formed warp is presented |
| out_ready | input | 1 | Consumer takes the presented warp |
| out_pc | output | PC_W | PC of the presented warp |
| out_mask | output | LANES | Occupied lanes of the presented warp |
| out_tid | output | LANES*TID_W | Thread ID per lane, zero on empty lanes |

## Verification
The bench uses four lanes and a four-slot pool with 8-bit thread IDs and 16-bit PCs. With only four slots, two outcomes with colliding lanes are enough to fill the pool, which brings the full-pool stall and its release by an issue within a few cycles. Four lanes keep every union, collision and tie small enough to predict by hand. Holding `out_ready` low while outcomes load lets the test build merges, collisions and ties before any warp leaves, and then check the exact issue order.

// File: rtl/warp_regroup_pkg.sv
package warp_regroup_pkg;

  // which staged group is being folded into the pool this cycle
  typedef enum logic [1:0] {
    SRC_NONE      = 2'd0,
    SRC_TAKEN     = 2'd1,
    SRC_FALLTHRU  = 2'd2
  } src_e;

  // what the fold step does with the selected group
  typedef enum logic [1:0] {
    ACT_IDLE  = 2'd0,
    ACT_MERGE = 2'd1,
    ACT_ALLOC = 2'd2,
    ACT_STALL = 2'd3
  } act_e;

endpackage

// File: rtl/wrg_pc_table.sv
module wrg_pc_table #(
  parameter int SLOTS = 4,
  parameter int PC_W  = 16,
  parameter int LANES = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  // lookup by PC
  input  logic [PC_W-1:0]  lk_pc,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_slot,
  output logic [LANES-1:0] lk_occ,
  output logic [IDX_W-1:0] lk_idx,
  // lowest unused slot
  output logic             free_any,
  output logic [IDX_W-1:0] free_slot,
  // write one slot
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_slot,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic [LANES-1:0] upd_occ,
  input  logic [IDX_W-1:0] upd_idx,
  // drop the slot that points at an issued pool warp
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);

  logic [SLOTS-1:0] v_q;
  logic [PC_W-1:0]  pc_q  [SLOTS];
  logic [LANES-1:0] occ_q [SLOTS];
  logic [IDX_W-1:0] idx_q [SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        // clear first so a re-point in the same cycle wins
        if (clr_en && v_q[s] && (idx_q[s] == clr_idx)) v_q[s] <= 1'b0;
        if (upd_en && (upd_slot == IDX_W'(s)))        v_q[s] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < SLOTS; s++) begin
      if (upd_en && (upd_slot == IDX_W'(s))) begin
        pc_q[s]  <= upd_pc;
        occ_q[s] <= upd_occ;
        idx_q[s] <= upd_idx;
      end
    end
  end

  always_comb begin
    lk_hit  = 1'b0;
    lk_slot = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!lk_hit && v_q[s] && (pc_q[s] == lk_pc)) begin
        lk_hit  = 1'b1;
        lk_slot = IDX_W'(s);
      end
    end
  end

  assign lk_occ = lk_hit ? occ_q[lk_slot] : '0;
  assign lk_idx = idx_q[lk_slot];

  always_comb begin
    free_any  = 1'b0;
    free_slot = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!free_any && !v_q[s]) begin
        free_any  = 1'b1;
        free_slot = IDX_W'(s);
      end
    end
  end

endmodule

// File: rtl/wrg_pool.sv
module wrg_pool #(
  parameter int POOL  = 4,
  parameter int PC_W  = 16,
  parameter int LANES = 4,
  parameter int TID_W = 8,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  // fold a group in
  input  logic                   wr_en,
  input  logic                   wr_alloc,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [PC_W-1:0]        wr_pc,
  input  logic [LANES-1:0]       wr_mask,
  input  logic [LANES*TID_W-1:0] wr_tid,
  // release an issued warp
  input  logic                   free_en,
  input  logic [IDX_W-1:0]       free_idx,
  // state for the picker
  output logic [POOL-1:0]        ent_valid,
  output logic [POOL*CNT_W-1:0]  ent_prio,
  output logic                   has_free,
  output logic [IDX_W-1:0]       free_pick,
  // read port for the issue side
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [PC_W-1:0]        rd_pc,
  output logic [LANES-1:0]       rd_mask,
  output logic [LANES*TID_W-1:0] rd_tid
);

  logic [POOL-1:0]        v_q;
  logic [PC_W-1:0]        pc_q   [POOL];
  logic [LANES-1:0]       mask_q [POOL];
  logic [LANES*TID_W-1:0] tid_q  [POOL];
  logic [CNT_W-1:0]       prio_q [POOL];

  logic [LANES-1:0]       new_mask;
  logic [LANES*TID_W-1:0] new_tid;

  function automatic logic [CNT_W-1:0] lane_count(input logic [LANES-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int l = 0; l < LANES; l++) c = c + CNT_W'(m[l]);
    return c;
  endfunction

  // lanes of the written warp after this fold
  always_comb begin
    new_mask = wr_alloc ? wr_mask : (mask_q[wr_idx] | wr_mask);
    new_tid  = tid_q[wr_idx];
    for (int l = 0; l < LANES; l++) begin
      if (wr_mask[l]) new_tid[l*TID_W +: TID_W] = wr_tid[l*TID_W +: TID_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
    end else begin
      if (free_en)             v_q[free_idx] <= 1'b0;
      if (wr_en && wr_alloc)   v_q[wr_idx]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      pc_q[wr_idx]   <= wr_pc;
      mask_q[wr_idx] <= new_mask;
      tid_q[wr_idx]  <= new_tid;
      prio_q[wr_idx] <= lane_count(new_mask);
    end
  end

  assign ent_valid = v_q;

  for (genvar g = 0; g < POOL; g++) begin : g_prio
    assign ent_prio[g*CNT_W +: CNT_W] = prio_q[g];
  end

  always_comb begin
    has_free  = 1'b0;
    free_pick = '0;
    for (int e = 0; e < POOL; e++) begin
      if (!has_free && !v_q[e]) begin
        has_free  = 1'b1;
        free_pick = IDX_W'(e);
      end
    end
  end

  assign rd_pc   = pc_q[rd_idx];
  assign rd_mask = mask_q[rd_idx];
  assign rd_tid  = tid_q[rd_idx];

endmodule

// File: rtl/wrg_pick.sv
module wrg_pick #(
  parameter int POOL  = 4,
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [POOL-1:0]       ent_valid,
  input  logic [POOL*CNT_W-1:0] ent_prio,
  output logic                  pick_v,
  output logic [IDX_W-1:0]      pick_idx
);

  logic [CNT_W-1:0] best;

  // strict greater-than keeps the lowest slot on equal counts
  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    best     = '0;
    for (int e = 0; e < POOL; e++) begin
      if (ent_valid[e] && (!pick_v || (ent_prio[e*CNT_W +: CNT_W] > best))) begin
        pick_v   = 1'b1;
        pick_idx = IDX_W'(e);
        best     = ent_prio[e*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/warp_regroup.sv
module warp_regroup
  import warp_regroup_pkg::*;
#(
  parameter int LANES = 4,
  parameter int TID_W = 8,
  parameter int PC_W  = 16,
  parameter int POOL  = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [PC_W-1:0]        in_tk_pc,
  input  logic [LANES-1:0]       in_tk_mask,
  input  logic [PC_W-1:0]        in_nt_pc,
  input  logic [LANES-1:0]       in_nt_mask,
  input  logic [LANES*TID_W-1:0] in_tid,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PC_W-1:0]        out_pc,
  output logic [LANES-1:0]       out_mask,
  output logic [LANES*TID_W-1:0] out_tid
);

  localparam int IDX_W = (POOL > 1) ? $clog2(POOL) : 1;
  localparam int CNT_W = $clog2(LANES + 1);
  localparam int TW    = LANES * TID_W;

  // staged groups
  logic             tk_v, nt_v;
  logic [PC_W-1:0]  tk_pc, nt_pc;
  logic [LANES-1:0] tk_mask, nt_mask;
  logic [TW-1:0]    tk_tid, nt_tid;

  // group selected for folding
  src_e             src;
  logic [PC_W-1:0]  req_pc;
  logic [LANES-1:0] req_mask;
  logic [TW-1:0]    req_tid;
  act_e             act;
  logic             consume;

  // table
  logic             lk_hit, lut_free_any, upd_en;
  logic [IDX_W-1:0] lk_slot, lk_idx, lut_free_slot, upd_slot, upd_idx;
  logic [LANES-1:0] lk_occ, upd_occ;

  // pool
  logic                  wr_alloc;
  logic [IDX_W-1:0]      wr_idx, pool_free_idx;
  logic                  pool_free_any;
  logic [POOL-1:0]       ent_valid;
  logic [POOL*CNT_W-1:0] ent_prio;
  logic [PC_W-1:0]       rd_pc;
  logic [LANES-1:0]      rd_mask;
  logic [TW-1:0]         rd_tid;

  // issue
  logic             pick_v, held_q, issue_fire;
  logic [IDX_W-1:0] pick_idx, held_idx_q, sel_idx;

  assign in_ready = !tk_v && !nt_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      tk_v <= 1'b0;
      nt_v <= 1'b0;
    end else if (in_valid && in_ready) begin
      tk_v <= |in_tk_mask;
      nt_v <= |in_nt_mask;
    end else if (consume) begin
      if (src == SRC_TAKEN)    tk_v <= 1'b0;
      if (src == SRC_FALLTHRU) nt_v <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      tk_pc   <= in_tk_pc;
      tk_mask <= in_tk_mask;
      tk_tid  <= in_tid;
      nt_pc   <= in_nt_pc;
      nt_mask <= in_nt_mask;
      nt_tid  <= in_tid;
    end
  end

  // taken group goes first
  always_comb begin
    src      = SRC_NONE;
    req_pc   = tk_pc;
    req_mask = tk_mask;
    req_tid  = tk_tid;
    if (tk_v) begin
      src = SRC_TAKEN;
    end else if (nt_v) begin
      src      = SRC_FALLTHRU;
      req_pc   = nt_pc;
      req_mask = nt_mask;
      req_tid  = nt_tid;
    end
  end

  wrg_pc_table #(
    .SLOTS(POOL), .PC_W(PC_W), .LANES(LANES), .IDX_W(IDX_W)
  ) u_table (
    .clk      (clk),
    .rst      (rst),
    .lk_pc    (req_pc),
    .lk_hit   (lk_hit),
    .lk_slot  (lk_slot),
    .lk_occ   (lk_occ),
    .lk_idx   (lk_idx),
    .free_any (lut_free_any),
    .free_slot(lut_free_slot),
    .upd_en   (upd_en),
    .upd_slot (upd_slot),
    .upd_pc   (req_pc),
    .upd_occ  (upd_occ),
    .upd_idx  (upd_idx),
    .clr_en   (issue_fire),
    .clr_idx  (sel_idx)
  );

  // fold decision
  always_comb begin
    act      = ACT_IDLE;
    wr_idx   = '0;
    wr_alloc = 1'b0;
    upd_slot = '0;
    upd_occ  = '0;
    upd_idx  = '0;
    if (src != SRC_NONE) begin
      if (lk_hit && ((lk_occ & req_mask) == '0)) begin
        if (issue_fire && (lk_idx == sel_idx)) begin
          act = ACT_STALL;            // target leaves this cycle
        end else begin
          act      = ACT_MERGE;
          wr_idx   = lk_idx;
          upd_slot = lk_slot;
          upd_occ  = lk_occ | req_mask;
          upd_idx  = lk_idx;
        end
      end else if (pool_free_any && (lk_hit || lut_free_any)) begin
        act      = ACT_ALLOC;
        wr_idx   = pool_free_idx;
        wr_alloc = 1'b1;
        upd_slot = lk_hit ? lk_slot : lut_free_slot;
        upd_occ  = req_mask;
        upd_idx  = pool_free_idx;
      end else begin
        act = ACT_STALL;
      end
    end
  end

  assign consume = (act == ACT_MERGE) || (act == ACT_ALLOC);
  assign upd_en  = consume;

  wrg_pool #(
    .POOL(POOL), .PC_W(PC_W), .LANES(LANES), .TID_W(TID_W),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_pool (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (consume),
    .wr_alloc (wr_alloc),
    .wr_idx   (wr_idx),
    .wr_pc    (req_pc),
    .wr_mask  (req_mask),
    .wr_tid   (req_tid),
    .free_en  (issue_fire),
    .free_idx (sel_idx),
    .ent_valid(ent_valid),
    .ent_prio (ent_prio),
    .has_free (pool_free_any),
    .free_pick(pool_free_idx),
    .rd_idx   (sel_idx),
    .rd_pc    (rd_pc),
    .rd_mask  (rd_mask),
    .rd_tid   (rd_tid)
  );

  wrg_pick #(
    .POOL(POOL), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_pick (
    .ent_valid(ent_valid),
    .ent_prio (ent_prio),
    .pick_v   (pick_v),
    .pick_idx (pick_idx)
  );

  // a presented warp stays selected until taken
  assign sel_idx    = held_q ? held_idx_q : pick_idx;
  assign out_valid  = held_q || pick_v;
  assign issue_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= 1'b0;
      held_idx_q <= '0;
    end else begin
      held_q     <= out_valid && !out_ready;
      held_idx_q <= sel_idx;
    end
  end

  assign out_pc   = out_valid ? rd_pc : '0;
  assign out_mask = out_valid ? rd_mask : '0;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_tid[l*TID_W +: TID_W] = out_mask[l] ? rd_tid[l*TID_W +: TID_W] : '0;
  end

endmodule

// File: rtl/warp_regroup_chk.sv
module warp_regroup_chk #(
  parameter int LANES = 4,
  parameter int PC_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [LANES-1:0] in_tk_mask,
  input logic [LANES-1:0] in_nt_mask,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PC_W-1:0]  out_pc,
  input logic [LANES-1:0] out_mask
);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && in_ready)); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pc) && (($past(out_mask) & ~out_mask) == '0))); // R10

  AST_OUT_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mask != '0)); // R11

  AST_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && ((in_tk_mask | in_nt_mask) != '0)) |=> !in_ready); // R12

endmodule

bind warp_regroup warp_regroup_chk #(.LANES(LANES), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_tk_mask(in_tk_mask),
  .in_nt_mask(in_nt_mask),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pc    (out_pc),
  .out_mask  (out_mask)
);

// File: tb/warp_regroup_bench.sv
`timescale 1ns/1ps
module warp_regroup_bench;

  localparam int LANES = 4;
  localparam int TID_W = 8;
  localparam int PC_W  = 16;
  localparam int POOL  = 4;
  localparam int TW    = LANES * TID_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [PC_W-1:0]  in_tk_pc = '0, in_nt_pc = '0;
  logic [LANES-1:0] in_tk_mask = '0, in_nt_mask = '0;
  logic [TW-1:0]    in_tid = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [PC_W-1:0]  out_pc;
  logic [LANES-1:0] out_mask;
  logic [TW-1:0]    out_tid;

  always #2.5 clk = ~clk;

  warp_regroup #(.LANES(LANES), .TID_W(TID_W), .PC_W(PC_W), .POOL(POOL)) u_warp_regroup (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_tk_pc(in_tk_pc), .in_tk_mask(in_tk_mask),
    .in_nt_pc(in_nt_pc), .in_nt_mask(in_nt_mask),
    .in_tid(in_tid),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_pc(out_pc), .out_mask(out_mask), .out_tid(out_tid)
  );

  typedef struct {
    logic [PC_W-1:0]  pc;
    logic [LANES-1:0] mask;
    logic [TW-1:0]    tid;
    string            tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  localparam logic [PC_W-1:0] PA = 16'h0100, PB = 16'h0200, PC_ = 16'h0300,
                              PD = 16'h0400, PE = 16'h0500, PF = 16'h0600,
                              PG = 16'h0700, PH = 16'h0800, PK = 16'h0900,
                              PL = 16'h0A00;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] mk(input int t0, input int t1, input int t2, input int t3);
    return {8'(t3), 8'(t2), 8'(t1), 8'(t0)};
  endfunction

  task automatic push(input logic [PC_W-1:0] pc, input logic [LANES-1:0] m,
                      input logic [TW-1:0] t, input string tag);
    exp_t e;
    e.pc = pc; e.mask = m; e.tid = t; e.tag = tag;
    q.push_back(e);
  endtask

  // driver: one branch outcome of static warp w
  task automatic send(input int w, input logic [PC_W-1:0] tpc, input logic [LANES-1:0] tm,
                      input logic [PC_W-1:0] npc, input logic [LANES-1:0] nm);
    @(posedge clk); #1;
    in_valid   = 1'b1;
    in_tk_pc   = tpc; in_tk_mask = tm;
    in_nt_pc   = npc; in_nt_mask = nm;
    in_tid     = mk(4*w, 4*w+1, 4*w+2, 4*w+3);
    forever begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk); #1;
        in_valid = 1'b0;
        break;
      end
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input string req);
    int guard;
    @(posedge clk); #1;
    out_ready = 1'b1;
    guard = 0;
    while (q.size() != 0 && guard < 60) begin
      @(negedge clk);
      guard++;
    end
    @(posedge clk); #1;
    out_ready = 1'b0;
    chk({req, " queue drained"}, 64'(q.size()), 64'd0);
    @(negedge clk);
    chk({req, " pool empty after drain"}, 64'(out_valid), 64'd0);
  endtask

  // monitor: compare every accepted warp with the queue head
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk("R5 unexpected warp pc", 64'(out_pc), 64'hFFFF_FFFF);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk({e.tag, " pc"},   64'(out_pc),   64'(e.pc));
          chk({e.tag, " mask"}, 64'(out_mask), 64'(e.mask));
          chk({e.tag, " R2 tid"}, 64'(out_tid), 64'(e.tid));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 in_ready",  64'(in_ready),  64'd1);

    // merge of disjoint lanes, home lanes kept
    send(0, PA, 4'b1010, PB, 4'b0101);
    chk("R12 in_ready after accept", 64'(in_ready), 64'd0);
    wait_cyc(3);
    chk("R10 presented pc", 64'(out_pc), 64'(PA));
    chk("R2 first group mask", 64'(out_mask), 64'(4'b1010));
    chk("R2 first group tid", 64'(out_tid), 64'(mk(0, 1, 0, 3)));
    send(1, PA, 4'b0101, PB, 4'b1010);
    wait_cyc(3);
    chk("R10 pc held while growing", 64'(out_pc), 64'(PA));
    chk("R3 union mask", 64'(out_mask), 64'(4'hF));
    push(PA, 4'hF, mk(4, 1, 6, 3), "R3 merged A");
    push(PB, 4'hF, mk(0, 5, 2, 7), "R3 merged B");
    drain("R3");

    // colliding lanes, then a full pool
    send(2, PC_, 4'b0011, PD, 4'b1100);
    send(3, PC_, 4'b0001, PD, 4'b0110);
    send(4, PE, 4'b1111, PH, 4'b0000);
    wait_cyc(3);
    chk("R8 in_ready while pool full", 64'(in_ready), 64'd0);
    chk("R8 presented pc while full", 64'(out_pc), 64'(PC_));
    push(PC_, 4'b0011, mk(8, 9, 0, 0),    "R4 first C");
    push(PD,  4'b1100, mk(0, 0, 10, 11),  "R6 tie lowest slot D");
    push(PE,  4'b1111, mk(16, 17, 18, 19), "R8 placed after free");
    push(PD,  4'b0110, mk(0, 13, 14, 0),  "R4 second D");
    push(PC_, 4'b0001, mk(12, 0, 0, 0),   "R5 smallest last");
    drain("R8");

    // empty group dropped, released entry not reused
    send(5, PF, 4'b0000, PG, 4'b0011);
    push(PG, 4'b0011, mk(20, 21, 0, 0), "R11 only fall-through");
    drain("R11");
    wait_cyc(3);
    chk("R11 no warp for empty group", 64'(out_valid), 64'd0);
    send(6, PG, 4'b1100, PH, 4'b0000);
    push(PG, 4'b1100, mk(0, 0, 26, 27), "R9 fresh warp");
    drain("R9");

    // taken group placed first
    send(7, PK, 4'b0011, PL, 4'b1100);
    push(PK, 4'b0011, mk(28, 29, 0, 0), "R7 taken first");
    push(PL, 4'b1100, mk(0, 0, 30, 31), "R7 fall-through second");
    drain("R7");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule